// File: doc/BRIEF.md
# Three-Instruction Accumulator Computer

A minimal 8-bit stored-program machine. Its 256-word program/data memory, its address, buffer, accumulator, auxiliary, program-counter and instruction registers, and its 3-bit step counter are all inside the block. A hardwired sequencer decodes the step counter into eight step lines and the instruction register into opcode lines. Their products form eight transfer enables, and these enables drive every register load and every memory read.

Each instruction begins with the same three steps. The first copies the program counter into the address register. The second reads memory into the buffer register and advances the program counter. The third moves the buffer into the instruction register. Operand steps then depend on the opcode. The step counter returns to zero when an instruction ends. A host fills memory through a write port, typically while reset is held, and loads the auxiliary register through its own write strobe. All registers are brought out for observation.

Top module: `tac_top`

## Requirements
- R1: While `rst` is high at a clock edge, every register (PC, MAR, MBR, A, R, IR and the 3-bit step counter) becomes 0.
- R2: The step counter increases by one on every clock. It returns to 0 only on the clock that ends an instruction.
- R3: Fetch: at step 0 MAR takes PC. At step 1 MBR takes the memory word at MAR and PC increases by one. At step 2 IR takes MBR.
- R4: Opcode 8'h01 copies R into A at step 3 and ends the instruction, so it takes 4 clocks.
- R5: Opcode 8'h02 loads A with the byte that follows the opcode. MAR takes PC at step 3. At step 4 MBR takes that byte and PC increases. At step 5 A takes MBR and the instruction ends, so it takes 6 clocks and PC advances by 2.
- R6: Opcode 8'h03 loads A with the memory word whose address is the byte after the opcode. Steps 3 and 4 behave as for 8'h02. At step 5 MAR takes MBR, at step 6 MBR takes memory, and at step 7 A takes MBR and the instruction ends. It takes 8 clocks and PC advances by 2.
- R7: Any other opcode leaves A unchanged and ends at step 3, so it takes 4 clocks and PC advances by 1.
- R8: A changes only at the steps named in R4, R5 and R6.
- R9: PC never changes by anything other than +1 per clock.
- R10: `mem_we` writes `mem_wdata` into memory at `mem_waddr`, including while reset is held. `r_we` loads R from `r_wdata` when reset is low. An opcode 8'h01 executed after such a load copies the new value.
- R11: PC is 8 bits wide and wraps from 8'hFF to 8'h00. An operand fetched from address 8'hFF is followed by a fetch from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_we | input | 1 | Memory preload write strobe |
| mem_waddr | input | 8 | Memory preload address |
| mem_wdata | input | 8 | Memory preload data |
| r_we | input | 1 | Auxiliary register write strobe |
| r_wdata | input | 8 | Auxiliary register write data |
| pc_o | output | 8 | Program counter |
| mar_o | output | 8 | Memory address register |
| mbr_o | output | 8 | Memory buffer register |
| acc_o | output | 8 | Accumulator |
| r_o | output | 8 | Auxiliary register |
| ir_o | output | 8 | Instruction register |
| t_o | output | 3 | Step counter |

## Verification
The hardest situation to reach from the ports is the PC wrap. It has to occur in the middle of an instruction, with the operand byte sitting at the last address. The preloaded program is padded with single-byte undefined opcodes, so execution sweeps the whole address space. At 8'hFE it meets a load-immediate whose operand lies at 8'hFF, so the operand fetch wraps PC to 0 and the program runs again. R is rewritten between the two passes, so the second copy-from-R has to show the new value.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam logic [7:0] OP_MOV = 8'h01;
  localparam logic [7:0] OP_LDI = 8'h02;
  localparam logic [7:0] OP_LDA = 8'h03;

  typedef struct packed {
    logic mar_pc;   // x1
    logic mar_mbr;  // x2
    logic pc_inc;   // x3
    logic mem_rd;   // x4
    logic a_mbr;    // x5
    logic a_r;      // x6
    logic t_clr;    // x7
    logic ir_ld;    // x8
  } xfer_t;
endpackage

// File: rtl/tac_ctrl.sv
module tac_ctrl
  import tac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int T_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ir,
  output logic [T_W-1:0]    t,
  output xfer_t             x
);
  localparam int NSTEP = 1 << T_W;

  logic [NSTEP-1:0] ts;
  for (genvar i = 0; i < NSTEP; i++) begin : g_step
    assign ts[i] = (t == T_W'(i));
  end

  logic q_mov, q_ldi, q_lda, q_bad, q_opd;
  assign q_mov = (ir == DATA_W'(OP_MOV));
  assign q_ldi = (ir == DATA_W'(OP_LDI));
  assign q_lda = (ir == DATA_W'(OP_LDA));
  assign q_bad = !(q_mov || q_ldi || q_lda);
  assign q_opd = q_ldi || q_lda;

  always_comb begin
    x.mar_pc  = ts[0] || (q_opd && ts[3]);
    x.mar_mbr = q_lda && ts[5];
    x.pc_inc  = ts[1] || (q_opd && ts[4]);
    x.mem_rd  = ts[1] || (q_opd && ts[4]) || (q_lda && ts[6]);
    x.a_mbr   = (q_ldi && ts[5]) || (q_lda && ts[7]);
    x.a_r     = q_mov && ts[3];
    x.ir_ld   = ts[2];
    x.t_clr   = ((q_mov || q_bad) && ts[3]) || (q_ldi && ts[5]) || (q_lda && ts[7]);
  end

  always_ff @(posedge clk) begin
    if (rst)          t <= '0;
    else if (x.t_clr) t <= '0;
    else              t <= t + T_W'(1);
  end

  AST_T_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !x.t_clr |=> t == $past(t) + T_W'(1)); // R2
  AST_T_RESTART: assert property (@(posedge clk) disable iff (rst)
    x.t_clr |=> t == '0); // R2
  AST_END_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
    x.t_clr |-> t >= T_W'(3)); // R7
endmodule

// File: rtl/tac_mem.sv
module tac_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // registered read port doubles as the buffer register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= ram[raddr];
  end

  AST_MBR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata)); // R3
endmodule

// File: rtl/tac_datapath.sv
module tac_datapath
  import tac_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  xfer_t             x,
  input  logic [DATA_W-1:0] mbr,
  input  logic              r_we,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] r,
  output logic [DATA_W-1:0] ir
);
  logic              mar_ld;
  logic [ADDR_W-1:0] mar_nxt;

  assign mar_ld  = x.mar_pc || x.mar_mbr;
  assign mar_nxt = x.mar_pc ? pc : mbr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      acc <= '0;
      r   <= '0;
      ir  <= '0;
    end else begin
      if (x.pc_inc) pc  <= pc + ADDR_W'(1);
      if (mar_ld)   mar <= mar_nxt;
      if (x.a_r)         acc <= r;
      else if (x.a_mbr)  acc <= mbr;
      if (r_we)     r   <= r_wdata;
      if (x.ir_ld)  ir  <= mbr;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc == $past(pc)) || (pc == $past(pc) + ADDR_W'(1))); // R9
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(x.a_mbr || x.a_r) |=> $stable(acc)); // R8
  AST_IR_FROM_MBR: assert property (@(posedge clk) disable iff (rst)
    x.ir_ld |=> ir == $past(mbr)); // R3
  AST_MAR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    x.mar_pc |=> mar == $past(pc)); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pc == '0) && (acc == '0) && (ir == '0) && (mar == '0)); // R1
endmodule

// File: rtl/tac_top.sv
module tac_top
  import tac_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int T_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic              r_we,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] r_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [T_W-1:0]    t_o
);
  xfer_t             x;
  logic [DATA_W-1:0] mbr;
  logic [DATA_W-1:0] ir;
  logic [ADDR_W-1:0] mar;

  tac_ctrl #(.DATA_W(DATA_W), .T_W(T_W)) u_ctrl (
    .clk(clk), .rst(rst), .ir(ir), .t(t_o), .x(x)
  );

  tac_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(x.mem_rd), .raddr(mar), .rdata(mbr)
  );

  tac_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .x(x), .mbr(mbr), .r_we(r_we), .r_wdata(r_wdata),
    .pc(pc_o), .mar(mar), .acc(acc_o), .r(r_o), .ir(ir)
  );

  assign mbr_o = mbr;
  assign ir_o  = ir;
  assign mar_o = mar;
endmodule

// File: tb/tac_top_bench.sv
module tac_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 2300;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mem_we = 1'b0;
  logic [7:0] mem_waddr = '0, mem_wdata = '0;
  logic       r_we = 1'b0;
  logic [7:0] r_wdata = '0;
  logic [7:0] pc_o, mar_o, mbr_o, acc_o, r_o, ir_o;
  logic [2:0] t_o;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tac_top u_tac_top (
    .clk(clk), .rst(rst), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .r_we(r_we), .r_wdata(r_wdata),
    .pc_o(pc_o), .mar_o(mar_o), .mbr_o(mbr_o), .acc_o(acc_o),
    .r_o(r_o), .ir_o(ir_o), .t_o(t_o)
  );

  function automatic int prog(input int a);
    case (a)
      0: return 'h02;  1: return 'h5A;           // load immediate
      2: return 'h01;                            // copy R
      3: return 'h03;  4: return 'h40;           // load from 0x40
      5: return 'h07;                            // undefined
      6: return 'h02;  7: return 'h00;
      8: return 'h03;  9: return 'hFF;
      'h40: return 'hC7;
      'hFE: return 'h02; 'hFF: return 'h81;      // operand at last address
      default: return 'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mem [256];
  int m_pc, m_mar, m_mbr, m_acc, m_r, m_ir, m_t;

  always @(posedge clk) begin
    int nt;
    bit done;
    if (rst) begin
      m_pc = 0; m_mar = 0; m_mbr = 0; m_acc = 0; m_r = 0; m_ir = 0; m_t = 0;
    end else begin
      done = 0;
      case (m_t)
        0: m_mar = m_pc;
        1: begin m_mbr = m_mem[m_mar]; m_pc = (m_pc + 1) % 256; end
        2: m_ir = m_mbr;
        3: if (m_ir == 1) begin m_acc = m_r; done = 1; end
           else if (m_ir == 2 || m_ir == 3) m_mar = m_pc;
           else done = 1;
        4: begin m_mbr = m_mem[m_mar]; m_pc = (m_pc + 1) % 256; end
        5: if (m_ir == 2) begin m_acc = m_mbr; done = 1; end
           else m_mar = m_mbr;
        6: m_mbr = m_mem[m_mar];
        default: begin m_acc = m_mbr; done = 1; end
      endcase
      nt = done ? 0 : m_t + 1;
      m_t = nt;
      if (r_we) m_r = r_wdata;
    end
    if (mem_we) m_mem[mem_waddr] = mem_wdata;
  end

  function automatic string acc_tag(input int op);
    case (op)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  int  cyc = 0;
  int  start_cyc = -1;
  int  prev_pc = 0;
  bit  wrapped = 0;
  bit  running = 0;

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      chk(t_o == m_t[2:0], "R2 step", t_o, m_t);
      chk(pc_o == m_pc[7:0], "R9 pc", pc_o, m_pc);
      chk(mar_o == m_mar[7:0], "R3 mar", mar_o, m_mar);
      chk(mbr_o == m_mbr[7:0], "R3 mbr", mbr_o, m_mbr);
      chk(ir_o == m_ir[7:0], "R3 ir", ir_o, m_ir);
      chk(acc_o == m_acc[7:0], {acc_tag(m_ir), " acc"}, acc_o, m_acc);
      chk(r_o == m_r[7:0], "R10 r", r_o, m_r);
      // R11: wrap from last address
      if (prev_pc == 'hFF && pc_o != 8'hFF) begin
        chk(pc_o == 8'h00, "R11 wrap", pc_o, 0);
        wrapped = 1;
      end
      prev_pc = pc_o;
      // instruction length, judged from the opcode just finished
      if (t_o == 3'd0) begin
        if (start_cyc >= 0) begin
          int exp_len;
          exp_len = (ir_o == 8'h02) ? 6 : (ir_o == 8'h03) ? 8 : 4;
          chk(cyc - start_cyc == exp_len, {acc_tag(ir_o), " length"}, cyc - start_cyc, exp_len);
          if (ir_o == 8'h01)
            chk(acc_o == r_o, "R4 R10 copy", acc_o, r_o);
        end
        start_cyc = cyc;
      end
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, RUN_CYCLES);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 0;
    // preload memory under reset (R10)
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      mem_we = 1'b1; mem_waddr = 8'(a); mem_wdata = 8'(prog(a));
    end
    @(negedge clk);
    mem_we = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pc_o == 0 && mar_o == 0 && mbr_o == 0, "R1 addr regs", {pc_o, mar_o, mbr_o}, 0);
    chk(acc_o == 0 && r_o == 0 && ir_o == 0 && t_o == 0, "R1 data regs", {acc_o, r_o, ir_o, 5'd0, t_o}, 0);
    rst = 1'b0;
    r_we = 1'b1; r_wdata = 8'h33;
    running = 1;
    @(negedge clk);
    r_we = 1'b0;
    // first instruction: load immediate done after 6 clocks (R5)
    repeat (5) @(negedge clk);
    chk(acc_o == 8'h5A, "R5 immediate", acc_o, 8'h5A);
    chk(pc_o == 8'h02, "R5 pc advance", pc_o, 8'h02);
    repeat (4) @(negedge clk);
    chk(acc_o == 8'h33, "R4 copy R", acc_o, 8'h33);
    repeat (8) @(negedge clk);
    chk(acc_o == 8'hC7, "R6 indirect", acc_o, 8'hC7);
    repeat (4) @(negedge clk);
    chk(acc_o == 8'hC7 && pc_o == 8'h06, "R7 undefined", {acc_o, pc_o}, 16'hC706);
    repeat (500) @(negedge clk);
    r_we = 1'b1; r_wdata = 8'h9C;   // new R for the second pass
    @(negedge clk);
    r_we = 1'b0;
    repeat (RUN_CYCLES - 523) @(negedge clk);
    chk(wrapped, "R11 wrap seen", wrapped, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule